// File: doc/BRIEF.md
# DDR Mode Register Command Decoder

This block sits on the memory side of a DDR SDRAM command bus. On each rising clock edge it samples the command strobes, the bank-select pair and the address bus. It picks out load-register commands aimed at the main mode register or the extended mode register. It accepts a load only when the device is in a state that allows it. On acceptance it holds the written word and presents the decoded burst settings and read latency to the rest of the device.

A load is checked against clock enable, the idle status of every bank, the order of programming (extended register first), the field codes and the recovery window after the previous load. A load that fails any check is refused and reported on a one-cycle error pulse. A refused load leaves every held value as it was. The read latency is given in half-cycle units, so the 2.5-cycle setting is a whole number on the port. A DLL reset request written into the main register gives a single-cycle pulse and is not held.

Top module: `mode_reg_decoder`

## Requirements
- R1: A load command is a rising edge with cs_ni, ras_ni, cas_ni and we_ni all low. Any other command (including all strobes low with cs_ni high) never updates a held value and, outside the recovery window, raises no error.
- R2: ba_i=00 targets the main mode register and ba_i=01 targets the extended register, whose full address word appears on ext_mode_o. ba_i=10 or 11 raises err_o and updates nothing.
- R3: A load is accepted only if cke_i is high at that edge and was high at the previous edge, and every bit of bank_idle_i is 1. Otherwise it raises err_o.
- R4: Main-register bits addr_i[2:0] give the burst length: 001→2, 010→4, 011→8 on burst_len_o. addr_i[3] gives burst_interleave_o (0 sequential, 1 interleave). Any other length code raises err_o.
- R5: Main-register bits addr_i[6:4] give the read latency in half cycles on cas_lat_half_o: 010→4, 011→6, 110→5. Any other code raises err_o.
- R6: A main-register load with addr_i[7]=1, or with any of addr_i[12:9] set, raises err_o.
- R7: After a load is accepted at edge k, any non-NOP command at edges k+1 to k+BUSY_CYCLES-1 raises err_o and is refused. A NOP is cs_ni high, or ras_ni, cas_ni and we_ni all high. A load at edge k+BUSY_CYCLES is judged normally.
- R8: A main-register load before any accepted extended load since reset raises err_o. configured_o goes high after the first accepted main load that follows an extended load, and stays high until reset.
- R9: Once configured, the main register may be rewritten any number of times under the same rules, and the outputs follow the newest accepted word.
- R10: An accepted main load with addr_i[8]=1 gives dll_reset_o high for exactly the next cycle. A refused load gives no pulse.
- R11: A refused load leaves burst_len_o, burst_interleave_o, cas_lat_half_o, ext_mode_o and configured_o unchanged.
- R12: All outputs are 0 while rst_ni is low. err_o is high only in the cycle after the offending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select / register target |
| addr_i | input | ADDR_W (13) | Address bus carrying the register word |
| bank_idle_i | input | NUM_BANKS (4) | One bit per bank, 1 when idle or precharged |
| burst_len_o | output | 4 | Burst length in beats (2, 4, 8) |
| burst_interleave_o | output | 1 | 1 for interleaved burst order |
| cas_lat_half_o | output | 4 | Read latency in half cycles (4, 5, 6) |
| dll_reset_o | output | 1 | One-cycle DLL reset request |
| configured_o | output | 1 | Extended then main register programmed |
| ext_mode_o | output | ADDR_W (13) | Word held in the extended register |
| err_o | output | 1 | One-cycle pulse for a refused command |

## Verification
The bench builds the block with four banks, a 13-bit address and BUSY_CYCLES set to 3 instead of the default 2. The wider window allows a NOP, a refused load and an accepted load to land at different edges inside and at the end of the same recovery period. The window edge at k+BUSY_CYCLES is then checked separately from the first edge after the load. The bank vector width lets a single non-idle bank show that the idle check looks at every bank.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [1:0] {
    TGT_MODE = 2'b00,
    TGT_EXT  = 2'b01,
    TGT_RSV2 = 2'b10,
    TGT_RSV3 = 2'b11
  } reg_tgt_e;

  typedef struct packed {
    logic [3:0] burst_len;
    logic       interleave;
    logic [3:0] cas_half;
    logic       dll_rst;
    logic       field_bad;
  } mode_fields_t;
endpackage

// File: rtl/mrd_cmd_decode.sv
module mrd_cmd_decode (
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output logic is_load_o,
  output logic is_nop_o
);
  assign is_load_o = ~cs_ni & ~ras_ni & ~cas_ni & ~we_ni;
  assign is_nop_o  = cs_ni | (ras_ni & cas_ni & we_ni);
endmodule

// File: rtl/mrd_field_decode.sv
module mrd_field_decode
  import mrd_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  output mode_fields_t      fields_o
);
  localparam int RSV_LO = 9;

  logic bl_bad, cl_bad, rsv_bad;

  always_comb begin
    fields_o.burst_len = 4'd0;
    bl_bad = 1'b0;
    unique case (addr_i[2:0])
      3'b001:  fields_o.burst_len = 4'd2;
      3'b010:  fields_o.burst_len = 4'd4;
      3'b011:  fields_o.burst_len = 4'd8;
      default: bl_bad = 1'b1;
    endcase
  end

  always_comb begin
    fields_o.cas_half = 4'd0;
    cl_bad = 1'b0;
    unique case (addr_i[6:4])
      3'b010:  fields_o.cas_half = 4'd4;
      3'b011:  fields_o.cas_half = 4'd6;
      3'b110:  fields_o.cas_half = 4'd5;   // 2.5 cycles
      default: cl_bad = 1'b1;
    endcase
  end

  // test-mode bit and upper reserved bits must be clear
  assign rsv_bad = addr_i[7] | (|addr_i[ADDR_W-1:RSV_LO]);

  assign fields_o.interleave = addr_i[3];
  assign fields_o.dll_rst    = addr_i[8];
  assign fields_o.field_bad  = bl_bad | cl_bad | rsv_bad;
endmodule

// File: rtl/mrd_busy_timer.sv
module mrd_busy_timer #(
  parameter int BUSY_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= RELOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mode_reg_decoder.sv
module mode_reg_decoder
  import mrd_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 13,
  parameter int BUSY_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_BANKS-1:0] bank_idle_i,
  output logic [3:0]        burst_len_o,
  output logic              burst_interleave_o,
  output logic [3:0]        cas_lat_half_o,
  output logic              dll_reset_o,
  output logic              configured_o,
  output logic [ADDR_W-1:0] ext_mode_o,
  output logic              err_o
);
  logic         is_load, is_nop, busy;
  logic         cke_q, ext_seen_q;
  logic         pre_ok, flag, acc_mode, acc_ext, wr_accept;
  mode_fields_t fields;
  reg_tgt_e     tgt;

  mrd_cmd_decode u_cmd (
    .cs_ni     (cs_ni),
    .ras_ni    (ras_ni),
    .cas_ni    (cas_ni),
    .we_ni     (we_ni),
    .is_load_o (is_load),
    .is_nop_o  (is_nop)
  );

  mrd_field_decode #(.ADDR_W(ADDR_W)) u_fields (
    .addr_i   (addr_i),
    .fields_o (fields)
  );

  mrd_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_accept),
    .busy_o  (busy)
  );

  assign tgt    = reg_tgt_e'(ba_i);
  assign pre_ok = cke_i & cke_q & (&bank_idle_i);

  always_comb begin
    flag     = 1'b0;
    acc_mode = 1'b0;
    acc_ext  = 1'b0;
    if (busy && !is_nop) begin
      flag = 1'b1;
    end else if (is_load) begin
      if (!pre_ok) begin
        flag = 1'b1;
      end else begin
        unique case (tgt)
          TGT_EXT:  acc_ext = 1'b1;
          TGT_MODE: begin
            if (!ext_seen_q || fields.field_bad) flag = 1'b1;
            else                                 acc_mode = 1'b1;
          end
          default:  flag = 1'b1;
        endcase
      end
    end
  end

  assign wr_accept = acc_mode | acc_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q              <= 1'b0;
      ext_seen_q         <= 1'b0;
      ext_mode_o         <= '0;
      burst_len_o        <= '0;
      burst_interleave_o <= 1'b0;
      cas_lat_half_o     <= '0;
      configured_o       <= 1'b0;
      dll_reset_o        <= 1'b0;
      err_o              <= 1'b0;
    end else begin
      cke_q       <= cke_i;
      err_o       <= flag;
      dll_reset_o <= acc_mode & fields.dll_rst;
      if (acc_ext) begin
        ext_seen_q <= 1'b1;
        ext_mode_o <= addr_i;
      end
      if (acc_mode) begin
        burst_len_o        <= fields.burst_len;
        burst_interleave_o <= fields.interleave;
        cas_lat_half_o     <= fields.cas_half;
        configured_o       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       ras_ni,
  input logic       cas_ni,
  input logic       we_ni,
  input logic [1:0] ba_i,
  input logic [3:0] burst_len_o,
  input logic [3:0] cas_lat_half_o,
  input logic       burst_interleave_o,
  input logic       dll_reset_o,
  input logic       configured_o,
  input logic       err_o,
  input logic       wr_accept
);
  logic load_cmd;
  assign load_cmd = !cs_ni && !ras_ni && !cas_ni && !we_ni;

  p_rsv_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_cmd && ba_i[1]) |=> err_o);

  p_bl_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |-> (burst_len_o == 4'd2 || burst_len_o == 4'd4 || burst_len_o == 4'd8));

  p_cl_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |-> (cas_lat_half_o == 4'd4 || cas_lat_half_o == 4'd5 || cas_lat_half_o == 4'd6));

  // BUSY_CYCLES >= 2 forbids accepts on adjacent edges
  p_no_adjacent_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_accept |=> !wr_accept);

  p_cfg_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |=> configured_o);

  p_dll_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |=> !dll_reset_o);

  p_dll_needs_cfg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |-> (configured_o && !err_o));

  p_hold_on_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(burst_len_o) && $stable(cas_lat_half_o) && $stable(burst_interleave_o)));
endmodule

bind mode_reg_decoder mrd_checker u_mrd_checker (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .cs_ni              (cs_ni),
  .ras_ni             (ras_ni),
  .cas_ni             (cas_ni),
  .we_ni              (we_ni),
  .ba_i               (ba_i),
  .burst_len_o        (burst_len_o),
  .cas_lat_half_o     (cas_lat_half_o),
  .burst_interleave_o (burst_interleave_o),
  .dll_reset_o        (dll_reset_o),
  .configured_o       (configured_o),
  .err_o              (err_o),
  .wr_accept          (wr_accept)
);

// File: tb/mode_reg_decoder_bench.sv
module mode_reg_decoder_bench;
  localparam int NB   = 4;
  localparam int AW   = 13;
  localparam int BUSY = 3;

  // kind: 0 NOP, 1 load, 2 activate, 3 load strobes with cs high
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [3:0]  idle;
    logic        err;
    logic [3:0]  bl;
    logic        il;
    logic [3:0]  cl;
    logic        cfg;
    logic        dll;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'b00, 13'h032, 4'hF, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0}, // R8 main before ext
    '{2'd1, 2'b01, 13'h002, 4'hF, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0}, // R2 ext
    '{2'd1, 2'b00, 13'h032, 4'hF, 1'b0, 4'd4, 1'b0, 4'd6, 1'b1, 1'b0}, // R4 R5 R8
    '{2'd1, 2'b00, 13'h16B, 4'hF, 1'b0, 4'd8, 1'b1, 4'd5, 1'b1, 1'b1}, // R4 R5 R10
    '{2'd1, 2'b00, 13'h021, 4'hF, 1'b0, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R9
    '{2'd1, 2'b00, 13'h020, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R4 bl 000
    '{2'd1, 2'b00, 13'h027, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R4 bl 111
    '{2'd1, 2'b00, 13'h012, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R5 cl 001
    '{2'd1, 2'b00, 13'h072, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R5 cl 111
    '{2'd1, 2'b00, 13'h0B2, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R6 test bit
    '{2'd1, 2'b00, 13'h432, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R6 reserved bit
    '{2'd1, 2'b10, 13'h032, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R2 ba 10
    '{2'd1, 2'b11, 13'h032, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R2 ba 11
    '{2'd1, 2'b00, 13'h033, 4'hB, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R3 bank busy
    '{2'd1, 2'b00, 13'h333, 4'hF, 1'b1, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R10 R11 refused dll
    '{2'd2, 2'b00, 13'h033, 4'hF, 1'b0, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R1 activate
    '{2'd3, 2'b00, 13'h033, 4'hF, 1'b0, 4'd2, 1'b0, 4'd4, 1'b1, 1'b0}, // R1 cs high
    '{2'd1, 2'b00, 13'h033, 4'hF, 1'b0, 4'd8, 1'b0, 4'd6, 1'b1, 1'b0}  // R9 rewrite
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cke_i = 1'b1;
  logic          cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]    ba_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [NB-1:0] bank_idle_i = '1;
  logic [3:0]    burst_len_o, cas_lat_half_o;
  logic          burst_interleave_o, dll_reset_o, configured_o, err_o;
  logic [AW-1:0] ext_mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  mode_reg_decoder #(.NUM_BANKS(NB), .ADDR_W(AW), .BUSY_CYCLES(BUSY)) u_mode_reg_decoder (
    .clk_i, .rst_ni, .cke_i, .cs_ni, .ras_ni, .cas_ni, .we_ni, .ba_i, .addr_i,
    .bank_idle_i, .burst_len_o, .burst_interleave_o, .cas_lat_half_o,
    .dll_reset_o, .configured_o, .ext_mode_o, .err_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic [1:0] kind, input logic [1:0] ba, input logic [AW-1:0] a);
    ba_i = ba; addr_i = a;
    unique case (kind)
      2'd0: {cs_ni, ras_ni, cas_ni, we_ni} = 4'b1111;
      2'd1: {cs_ni, ras_ni, cas_ni, we_ni} = 4'b0000;
      2'd2: {cs_ni, ras_ni, cas_ni, we_ni} = 4'b0011;
      default: {cs_ni, ras_ni, cas_ni, we_ni} = 4'b1000;
    endcase
  endtask

  // drive at negedge, one rising edge, return at next negedge
  task automatic step(input logic [1:0] kind, input logic [1:0] ba, input logic [AW-1:0] a);
    set_cmd(kind, ba, a);
    @(posedge clk_i);
    @(negedge clk_i);
    set_cmd(2'd0, 2'b00, '0);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(2'd0, 2'b00, '0);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    check("R12 reset bl", burst_len_o, 0);
    check("R12 reset cl", cas_lat_half_o, 0);
    check("R12 reset cfg", configured_o, 0);
    check("R12 reset err", err_o, 0);
    check("R12 reset ext", ext_mode_o, 0);
    rst_ni = 1'b1;
    nops(2);

    for (int v = 0; v < NV; v++) begin
      bank_idle_i = VECS[v].idle;
      step(VECS[v].kind, VECS[v].ba, VECS[v].addr);
      bank_idle_i = '1;
      check($sformatf("R11 vec%0d err", v), err_o, VECS[v].err);
      check($sformatf("R4 vec%0d bl", v), burst_len_o, VECS[v].bl);
      check($sformatf("R4 vec%0d il", v), burst_interleave_o, VECS[v].il);
      check($sformatf("R5 vec%0d cl", v), cas_lat_half_o, VECS[v].cl);
      check($sformatf("R8 vec%0d cfg", v), configured_o, VECS[v].cfg);
      check($sformatf("R10 vec%0d dll", v), dll_reset_o, VECS[v].dll);
      if (v == 1) check("R2 ext word", ext_mode_o, 13'h002);
      nops(BUSY);
      check($sformatf("R12 vec%0d err cleared", v), err_o, 0);
      check($sformatf("R10 vec%0d dll cleared", v), dll_reset_o, 0);
    end

    // R7: NOP inside window is fine, load inside refused, load at window end accepted
    step(2'd1, 2'b01, 13'h0A5);
    check("R2 ext latched", ext_mode_o, 13'h0A5);
    step(2'd0, 2'b00, '0);
    check("R7 nop in window", err_o, 0);
    step(2'd1, 2'b00, 13'h021);
    check("R7 load in window err", err_o, 1);
    check("R7 load in window held", burst_len_o, 8);
    step(2'd1, 2'b00, 13'h021);
    check("R7 load at window end", err_o, 0);
    check("R7 load at window end bl", burst_len_o, 2);
    step(2'd2, 2'b00, '0);
    check("R7 activate next edge", err_o, 1);
    nops(BUSY);

    // R3: cke low at previous edge
    cke_i = 1'b0;
    step(2'd0, 2'b00, '0);
    cke_i = 1'b1;
    step(2'd1, 2'b00, 13'h032);
    check("R3 cke was low", err_o, 1);
    check("R3 cke was low held", burst_len_o, 2);
    cke_i = 1'b0;
    step(2'd1, 2'b01, 13'h011);
    cke_i = 1'b1;
    check("R3 cke low now", err_o, 1);
    check("R11 ext held", ext_mode_o, 13'h0A5);
    nops(1);
    step(2'd1, 2'b00, 13'h032);
    check("R3 cke restored", err_o, 0);
    check("R9 bl after restore", burst_len_o, 4);
    nops(BUSY);

    // R12 R8: reset mid-run clears state and order rule
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R12 mid reset cfg", configured_o, 0);
    check("R12 mid reset bl", burst_len_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    nops(1);
    step(2'd1, 2'b00, 13'h032);
    check("R8 order after reset", err_o, 1);
    check("R8 cfg after reset", configured_o, 0);
    nops(BUSY);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule